// File: doc/BRIEF.md
# DMA Control Register Write Decoder

This block sits on the byte-wide programming port of a single-channel DMA controller. Software writes one byte at a time. When no parameter bytes are outstanding, the byte is a base byte. The decoder sorts it into a register group, acts on it, and loads an ordered list of the parameter bytes that must follow. The bytes written after that fill the list entries in order. Command bytes act on the two port address counters, the byte counter, the match and end-of-block flags, the pending address step and the channel enable.

The transfer engine reads the stored register contents and the live counter values from the block's outputs. The engine reports back through three single-cycle inputs: a byte was moved, a match was seen, and the end of the block was reached. The block does not move any data itself.

Top module: `dma_wr_decoder`

## Requirements
- R1: After reset, every stored register, counter, flag and enable is zero, and the pending count is zero.
- R2: A base byte with bit 7 = 0 and bits 1:0 not 00 is stored as the transfer-mode byte. Its bits 3, 4, 5 and 6 queue, in this order, port A start low, port A start high, block length low and block length high. The first parameter byte written goes to the first queued entry.
- R3: A base byte with bit 7 = 0 and bits 1:0 = 00 is stored as the port A configuration (bit 2 = 1) or as the port B configuration (bit 2 = 0). Its bit 6 queues one timing byte. The timing byte is consumed and changes no output except the pending count.
- R4: A base byte of the form 1xxxxx00 queues a mask byte (bit 3) and then a match byte (bit 4). It loads the interrupt enable from bit 5, and bit 6 = 1 sets the channel enable.
- R5: A base byte of the form 1xxxxx01 loads the operating mode from bits 6:5. Its bits 2, 3 and 4 queue port B start low, port B start high and the interrupt control byte. When bits 6:5 = 11, the byte changes nothing and queues nothing.
- R6: When the interrupt control byte is consumed, its bit 3 appends a pulse byte and then its bit 4 appends a vector byte to the end of the pending list.
- R7: A base byte of the form 1xxxxx10 is stored as the ready-control byte only when bits 6 and 2 are both 0. Otherwise it has no effect.
- R8: Command 0xCF (load) copies the port A and port B start addresses into the two counters. It also clears the byte counter and both flags.
- R9: Command 0xD3 (continue) first handles a pending address step. If one is pending, each port counter decrements when its configuration bits 5:4 = 00, increments when they are 01, and holds otherwise. The command then clears the step, the byte counter and both flags, and it sets the channel enable.
- R10: Command 0xC3 (reset) clears bits 1:0 of the transfer-mode byte, the pending step and the interrupt enable. The channel enable is left as it was.
- R11: Command 0x87 clears the pending step and sets the channel enable. Command 0x8B clears both flags. Command 0xAB sets the interrupt enable, and command 0xAF clears it.
- R12: Command 0xBB queues a read-mask byte. Consuming that byte stores it and pulses the read-restart output. Command 0xBF sets the read mask to 0x01 and pulses read-restart. Command 0xA7 pulses read-restart. Command 0xB3 pulses force-ready. Each pulse lasts one cycle.
- R13: A moved-byte report sets the pending step and increments the byte counter. Match and end-of-block reports set their flags. A clearing command in the same cycle as a report wins over the report.
- R14: The pending count never exceeds 8, and it falls by one on each parameter byte that appends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Written byte |
| step_i | input | 1 | Engine moved one byte |
| match_i | input | 1 | Engine saw a match |
| endb_i | input | 1 | Engine reached end of block |
| xfer_mode_o | output | 8 | Transfer-mode byte |
| cfg_a_o | output | 8 | Port A configuration |
| cfg_b_o | output | 8 | Port B configuration |
| op_mode_o | output | 2 | Operating mode |
| ready_ctl_o | output | 8 | Ready-control byte |
| start_a_o | output | 16 | Port A start address |
| start_b_o | output | 16 | Port B start address |
| blk_len_o | output | 16 | Block length |
| cnt_a_o | output | 16 | Port A address counter |
| cnt_b_o | output | 16 | Port B address counter |
| byte_cnt_o | output | 16 | Byte counter |
| mask_o | output | 8 | Match mask byte |
| match_val_o | output | 8 | Match value byte |
| int_ctl_o | output | 8 | Interrupt control byte |
| int_pulse_o | output | 8 | Pulse byte |
| int_vec_o | output | 8 | Vector byte |
| rd_mask_o | output | 8 | Read mask |
| int_en_o | output | 1 | Interrupt enable |
| chan_en_o | output | 1 | Channel enable |
| match_flag_o | output | 1 | Match flag |
| endb_flag_o | output | 1 | End-of-block flag |
| step_pend_o | output | 1 | Address step pending |
| rd_restart_o | output | 1 | Read sequence restart pulse |
| force_ready_o | output | 1 | Force-ready pulse |
| pend_cnt_o | output | 4 | Parameter bytes still expected |

## Verification
Every result is registered on the rising edge that ends the write or report cycle. Stored bytes, counters, flags, enables, the pending count and the two pulses are therefore all due exactly one cycle after the stimulus. The bench drives each stimulus on a falling edge and samples on the next falling edge. The pulses are sampled there as high, and sampled one cycle later as low, so a pulse that is late or lasts too long is caught.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned ADDR_W = 2 * BYTE_W;
  parameter int unsigned LIST_N = 4;  // most entries one base byte can queue

  typedef enum logic [3:0] {
    T_NONE, T_A_LO, T_A_HI, T_LEN_LO, T_LEN_HI, T_TIMING, T_MASK, T_MATCH,
    T_B_LO, T_B_HI, T_INT_CTL, T_PULSE, T_VECTOR, T_RD_MASK
  } tgt_e;

  typedef struct packed {
    logic wr_xfer;
    logic wr_cfg_a;
    logic wr_cfg_b;
    logic wr_grp;
    logic wr_mode;
    logic wr_ready;
    logic c_enable;
    logic c_clr;
    logic c_rd_start;
    logic c_int_on;
    logic c_int_off;
    logic c_force;
    logic c_rd_status;
    logic c_reset;
    logic c_load;
    logic c_cont;
  } act_t;
endpackage

// File: rtl/dma_base_decode.sv
module dma_base_decode
  import dma_wr_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output act_t              act_o,
  output tgt_e              list_o [LIST_N],
  output logic [2:0]        list_cnt_o
);
  logic [2:0] n;

  always_comb begin
    act_o = '0;
    n     = '0;
    for (int i = 0; i < LIST_N; i++) list_o[i] = T_NONE;
    if (!byte_i[7]) begin
      if (byte_i[1:0] != 2'b00) begin
        act_o.wr_xfer = 1'b1;
        if (byte_i[3]) begin list_o[n[1:0]] = T_A_LO;   n = n + 3'd1; end
        if (byte_i[4]) begin list_o[n[1:0]] = T_A_HI;   n = n + 3'd1; end
        if (byte_i[5]) begin list_o[n[1:0]] = T_LEN_LO; n = n + 3'd1; end
        if (byte_i[6]) begin list_o[n[1:0]] = T_LEN_HI; n = n + 3'd1; end
      end else begin
        act_o.wr_cfg_a = byte_i[2];
        act_o.wr_cfg_b = !byte_i[2];
        if (byte_i[6]) begin list_o[0] = T_TIMING; n = 3'd1; end
      end
    end else begin
      unique case (byte_i[1:0])
        2'b00: begin
          act_o.wr_grp = 1'b1;
          if (byte_i[3]) begin list_o[n[1:0]] = T_MASK;  n = n + 3'd1; end
          if (byte_i[4]) begin list_o[n[1:0]] = T_MATCH; n = n + 3'd1; end
        end
        2'b01: begin
          if (byte_i[6:5] != 2'b11) begin
            act_o.wr_mode = 1'b1;
            if (byte_i[2]) begin list_o[n[1:0]] = T_B_LO;    n = n + 3'd1; end
            if (byte_i[3]) begin list_o[n[1:0]] = T_B_HI;    n = n + 3'd1; end
            if (byte_i[4]) begin list_o[n[1:0]] = T_INT_CTL; n = n + 3'd1; end
          end
        end
        2'b10: act_o.wr_ready = !byte_i[6] && !byte_i[2];
        default: begin
          unique case (byte_i)
            8'h87: act_o.c_enable    = 1'b1;
            8'h8B: act_o.c_clr       = 1'b1;
            8'hA7: act_o.c_rd_start  = 1'b1;
            8'hAB: act_o.c_int_on    = 1'b1;
            8'hAF: act_o.c_int_off   = 1'b1;
            8'hB3: act_o.c_force     = 1'b1;
            8'hBB: begin list_o[0] = T_RD_MASK; n = 3'd1; end
            8'hBF: act_o.c_rd_status = 1'b1;
            8'hC3: act_o.c_reset     = 1'b1;
            8'hCF: act_o.c_load      = 1'b1;
            8'hD3: act_o.c_cont      = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
    list_cnt_o = n;
  end
endmodule

// File: rtl/dma_param_queue.sv
module dma_param_queue
  import dma_wr_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  tgt_e                         ld_list_i [LIST_N],
  input  logic [2:0]                   ld_cnt_i,
  input  logic                         pop_i,
  input  logic                         app_pulse_i,
  input  logic                         app_vec_i,
  output tgt_e                         head_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  tgt_e          q_q [DEPTH];
  tgt_e          q_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (load_i) begin
      for (int i = 0; i < LIST_N; i++) q_d[i] = ld_list_i[i];
      for (int i = LIST_N; i < DEPTH; i++) q_d[i] = T_NONE;
      cnt_d = CW'(ld_cnt_i);
    end else if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) q_d[i] = q_q[i+1];
      q_d[DEPTH-1] = T_NONE;
      cnt_d = cnt_q - CW'(1);
      // appended entries go behind whatever is still outstanding
      if (app_pulse_i && cnt_d < CW'(DEPTH)) begin
        q_d[cnt_d[IW-1:0]] = T_PULSE;
        cnt_d = cnt_d + CW'(1);
      end
      if (app_vec_i && cnt_d < CW'(DEPTH)) begin
        q_d[cnt_d[IW-1:0]] = T_VECTOR;
        cnt_d = cnt_d + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= T_NONE;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign head_o = q_q[0];
  assign cnt_o  = cnt_q;

  // R14
  cnt_le_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R14
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !load_i && cnt_q != '0 && !app_pulse_i && !app_vec_i)
      |=> cnt_q == $past(cnt_q) - CW'(1));

  // R6
  append_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !load_i && cnt_q == CW'(1) && app_pulse_i && app_vec_i)
      |=> (cnt_q == CW'(2) && q_q[0] == T_PULSE && q_q[1] == T_VECTOR));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  act_t              act_i,
  input  logic              par_we_i,
  input  tgt_e              head_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              step_i,
  input  logic              match_i,
  input  logic              endb_i,
  output logic [BYTE_W-1:0] xfer_mode_o,
  output logic [BYTE_W-1:0] cfg_a_o,
  output logic [BYTE_W-1:0] cfg_b_o,
  output logic [1:0]        op_mode_o,
  output logic [BYTE_W-1:0] ready_ctl_o,
  output logic [ADDR_W-1:0] start_a_o,
  output logic [ADDR_W-1:0] start_b_o,
  output logic [ADDR_W-1:0] blk_len_o,
  output logic [ADDR_W-1:0] cnt_a_o,
  output logic [ADDR_W-1:0] cnt_b_o,
  output logic [ADDR_W-1:0] byte_cnt_o,
  output logic [BYTE_W-1:0] mask_o,
  output logic [BYTE_W-1:0] match_val_o,
  output logic [BYTE_W-1:0] int_ctl_o,
  output logic [BYTE_W-1:0] int_pulse_o,
  output logic [BYTE_W-1:0] int_vec_o,
  output logic [BYTE_W-1:0] rd_mask_o,
  output logic              int_en_o,
  output logic              chan_en_o,
  output logic              match_flag_o,
  output logic              endb_flag_o,
  output logic              step_pend_o,
  output logic              rd_restart_o,
  output logic              force_ready_o
);
  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic [1:0] dir);
    unique case (dir)
      2'b00:   return a - ADDR_W'(1);
      2'b01:   return a + ADDR_W'(1);
      default: return a;
    endcase
  endfunction

  logic do_load, do_cont, clr_flags;
  assign do_load   = base_we_i && act_i.c_load;
  assign do_cont   = base_we_i && act_i.c_cont;
  assign clr_flags = base_we_i && (act_i.c_load || act_i.c_cont || act_i.c_clr);

  // base registers and enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_mode_o <= '0;
      cfg_a_o     <= '0;
      cfg_b_o     <= '0;
      op_mode_o   <= '0;
      ready_ctl_o <= '0;
      int_en_o    <= 1'b0;
      chan_en_o   <= 1'b0;
    end else if (base_we_i) begin
      if (act_i.wr_xfer)  xfer_mode_o <= data_i;
      if (act_i.c_reset)  xfer_mode_o[1:0] <= 2'b00;
      if (act_i.wr_cfg_a) cfg_a_o <= data_i;
      if (act_i.wr_cfg_b) cfg_b_o <= data_i;
      if (act_i.wr_mode)  op_mode_o <= data_i[6:5];
      if (act_i.wr_ready) ready_ctl_o <= data_i;
      if (act_i.wr_grp)   int_en_o <= data_i[5];
      if (act_i.c_int_on) int_en_o <= 1'b1;
      if (act_i.c_int_off || act_i.c_reset) int_en_o <= 1'b0;
      if ((act_i.wr_grp && data_i[6]) || act_i.c_enable || act_i.c_cont) chan_en_o <= 1'b1;
    end
  end

  // parameter bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_a_o   <= '0;
      start_b_o   <= '0;
      blk_len_o   <= '0;
      mask_o      <= '0;
      match_val_o <= '0;
      int_ctl_o   <= '0;
      int_pulse_o <= '0;
      int_vec_o   <= '0;
      rd_mask_o   <= '0;
    end else begin
      if (par_we_i) begin
        unique case (head_i)
          T_A_LO:    start_a_o[BYTE_W-1:0]      <= data_i;
          T_A_HI:    start_a_o[ADDR_W-1:BYTE_W] <= data_i;
          T_B_LO:    start_b_o[BYTE_W-1:0]      <= data_i;
          T_B_HI:    start_b_o[ADDR_W-1:BYTE_W] <= data_i;
          T_LEN_LO:  blk_len_o[BYTE_W-1:0]      <= data_i;
          T_LEN_HI:  blk_len_o[ADDR_W-1:BYTE_W] <= data_i;
          T_MASK:    mask_o      <= data_i;
          T_MATCH:   match_val_o <= data_i;
          T_INT_CTL: int_ctl_o   <= data_i;
          T_PULSE:   int_pulse_o <= data_i;
          T_VECTOR:  int_vec_o   <= data_i;
          T_RD_MASK: rd_mask_o   <= data_i;
          default:   ;  // timing byte is dropped
        endcase
      end
      if (base_we_i && act_i.c_rd_status) rd_mask_o <= BYTE_W'(1);
    end
  end

  // counters, step and flags; commands win over engine reports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a_o      <= '0;
      cnt_b_o      <= '0;
      byte_cnt_o   <= '0;
      step_pend_o  <= 1'b0;
      match_flag_o <= 1'b0;
      endb_flag_o  <= 1'b0;
    end else begin
      if (do_load) begin
        cnt_a_o <= start_a_o;
        cnt_b_o <= start_b_o;
      end else if (do_cont && step_pend_o) begin
        cnt_a_o <= step_addr(cnt_a_o, cfg_a_o[5:4]);
        cnt_b_o <= step_addr(cnt_b_o, cfg_b_o[5:4]);
      end
      if (do_load || do_cont)  byte_cnt_o <= '0;
      else if (step_i)         byte_cnt_o <= byte_cnt_o + ADDR_W'(1);
      if (base_we_i && (act_i.c_enable || act_i.c_cont || act_i.c_reset)) step_pend_o <= 1'b0;
      else if (step_i) step_pend_o <= 1'b1;
      if (clr_flags) begin
        match_flag_o <= 1'b0;
        endb_flag_o  <= 1'b0;
      end else begin
        if (match_i) match_flag_o <= 1'b1;
        if (endb_i)  endb_flag_o  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_restart_o  <= 1'b0;
      force_ready_o <= 1'b0;
    end else begin
      rd_restart_o  <= (base_we_i && (act_i.c_rd_start || act_i.c_rd_status))
                    || (par_we_i && head_i == T_RD_MASK);
      force_ready_o <= base_we_i && act_i.c_force;
    end
  end

  // R8
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_load |=> (cnt_a_o == $past(start_a_o) && cnt_b_o == $past(start_b_o)
                 && byte_cnt_o == '0 && !match_flag_o && !endb_flag_o));

  // R9
  cont_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cont && step_pend_o && cfg_a_o[5:4] == 2'b01)
      |=> cnt_a_o == $past(cnt_a_o) + ADDR_W'(1));

  // R9
  cont_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cont && !step_pend_o) |=> ($stable(cnt_a_o) && $stable(cnt_b_o) && chan_en_o));

  // R10
  reset_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_i && act_i.c_reset) |=> (!int_en_o && !step_pend_o && xfer_mode_o[1:0] == 2'b00));

  // R13
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags |=> (!match_flag_o && !endb_flag_o));
endmodule

// File: rtl/dma_wr_decoder.sv
module dma_wr_decoder
  import dma_wr_pkg::*;
#(
  parameter int unsigned QDEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              step_i,
  input  logic              match_i,
  input  logic              endb_i,
  output logic [7:0]        xfer_mode_o,
  output logic [7:0]        cfg_a_o,
  output logic [7:0]        cfg_b_o,
  output logic [1:0]        op_mode_o,
  output logic [7:0]        ready_ctl_o,
  output logic [15:0]       start_a_o,
  output logic [15:0]       start_b_o,
  output logic [15:0]       blk_len_o,
  output logic [15:0]       cnt_a_o,
  output logic [15:0]       cnt_b_o,
  output logic [15:0]       byte_cnt_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        match_val_o,
  output logic [7:0]        int_ctl_o,
  output logic [7:0]        int_pulse_o,
  output logic [7:0]        int_vec_o,
  output logic [7:0]        rd_mask_o,
  output logic              int_en_o,
  output logic              chan_en_o,
  output logic              match_flag_o,
  output logic              endb_flag_o,
  output logic              step_pend_o,
  output logic              rd_restart_o,
  output logic              force_ready_o,
  output logic [3:0]        pend_cnt_o
);
  localparam int unsigned CW = $clog2(QDEPTH + 1);

  act_t          act;
  tgt_e          list [LIST_N];
  logic [2:0]    list_cnt;
  tgt_e          head;
  logic [CW-1:0] cnt;
  logic          base_we, par_we;

  assign base_we    = wr_en_i && cnt == '0;
  assign par_we     = wr_en_i && cnt != '0;
  assign pend_cnt_o = 4'(cnt);

  dma_base_decode u_dec (
    .byte_i     (wr_data_i),
    .act_o      (act),
    .list_o     (list),
    .list_cnt_o (list_cnt)
  );

  dma_param_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (base_we),
    .ld_list_i   (list),
    .ld_cnt_i    (list_cnt),
    .pop_i       (par_we),
    .app_pulse_i (head == T_INT_CTL && wr_data_i[3]),
    .app_vec_i   (head == T_INT_CTL && wr_data_i[4]),
    .head_o      (head),
    .cnt_o       (cnt)
  );

  dma_regfile u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .base_we_i     (base_we),
    .act_i         (act),
    .par_we_i      (par_we),
    .head_i        (head),
    .data_i        (wr_data_i),
    .step_i        (step_i),
    .match_i       (match_i),
    .endb_i        (endb_i),
    .xfer_mode_o   (xfer_mode_o),
    .cfg_a_o       (cfg_a_o),
    .cfg_b_o       (cfg_b_o),
    .op_mode_o     (op_mode_o),
    .ready_ctl_o   (ready_ctl_o),
    .start_a_o     (start_a_o),
    .start_b_o     (start_b_o),
    .blk_len_o     (blk_len_o),
    .cnt_a_o       (cnt_a_o),
    .cnt_b_o       (cnt_b_o),
    .byte_cnt_o    (byte_cnt_o),
    .mask_o        (mask_o),
    .match_val_o   (match_val_o),
    .int_ctl_o     (int_ctl_o),
    .int_pulse_o   (int_pulse_o),
    .int_vec_o     (int_vec_o),
    .rd_mask_o     (rd_mask_o),
    .int_en_o      (int_en_o),
    .chan_en_o     (chan_en_o),
    .match_flag_o  (match_flag_o),
    .endb_flag_o   (endb_flag_o),
    .step_pend_o   (step_pend_o),
    .rd_restart_o  (rd_restart_o),
    .force_ready_o (force_ready_o)
  );

  // R5
  mode11_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we && wr_data_i[7] && wr_data_i[6:5] == 2'b11 && wr_data_i[1:0] == 2'b01)
      |=> (pend_cnt_o == '0 && $stable(op_mode_o)));

  // R7
  ready_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we && wr_data_i[7] && wr_data_i[1:0] == 2'b10 && (wr_data_i[6] || wr_data_i[2]))
      |=> $stable(ready_ctl_o));

  // R3
  timing_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_we && head == T_TIMING)
      |=> ($stable(start_a_o) && $stable(start_b_o) && $stable(blk_len_o) && $stable(mask_o)));
endmodule

// File: tb/dma_wr_decoder_test.sv
`timescale 1ns/1ps
module dma_wr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        step = 1'b0, match = 1'b0, endb = 1'b0;
  logic [7:0]  xfer_mode, cfg_a, cfg_b, ready_ctl, mask, match_val, int_ctl, int_pulse, int_vec, rd_mask;
  logic [1:0]  op_mode;
  logic [15:0] start_a, start_b, blk_len, cnt_a, cnt_b, byte_cnt;
  logic        int_en, chan_en, match_flag, endb_flag, step_pend, rd_restart, force_ready;
  logic [3:0]  pend_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_wr_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .step_i(step), .match_i(match), .endb_i(endb),
    .xfer_mode_o(xfer_mode), .cfg_a_o(cfg_a), .cfg_b_o(cfg_b), .op_mode_o(op_mode),
    .ready_ctl_o(ready_ctl), .start_a_o(start_a), .start_b_o(start_b), .blk_len_o(blk_len),
    .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .byte_cnt_o(byte_cnt), .mask_o(mask),
    .match_val_o(match_val), .int_ctl_o(int_ctl), .int_pulse_o(int_pulse), .int_vec_o(int_vec),
    .rd_mask_o(rd_mask), .int_en_o(int_en), .chan_en_o(chan_en), .match_flag_o(match_flag),
    .endb_flag_o(endb_flag), .step_pend_o(step_pend), .rd_restart_o(rd_restart),
    .force_ready_o(force_ready), .pend_cnt_o(pend_cnt)
  );

  function automatic logic [15:0] exp_step(logic [15:0] a, logic [1:0] dir);
    if (dir == 2'b00) return a - 16'd1;
    if (dir == 2'b01) return a + 16'd1;
    return a;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one-cycle write; results are sampled on the next falling edge
  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rep(logic s, logic m, logic e);
    @(negedge clk); step = s; match = m; endb = e;
    @(negedge clk); step = 1'b0; match = 1'b0; endb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pend", pend_cnt, 0);
    chk("R1", "cnt_a", cnt_a, 0);
    chk("R1", "chan_en", chan_en, 0);
    chk("R1", "xfer", xfer_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 full transfer-mode list
    wr(8'h79);
    chk("R2", "xfer", xfer_mode, 8'h79);
    chk("R14", "pend after base", pend_cnt, 4);
    wr(8'h34);
    chk("R14", "pend dec", pend_cnt, 3);
    wr(8'h12); wr(8'h78); wr(8'h56);
    chk("R2", "start_a", start_a, 16'h1234);
    chk("R2", "blk_len", blk_len, 16'h5678);
    chk("R2", "pend", pend_cnt, 0);
    // R2 partial list keeps order
    wr(8'h29);
    chk("R2", "pend partial", pend_cnt, 2);
    wr(8'hAA); wr(8'hBB);
    chk("R2", "start_a low", start_a, 16'h12AA);
    chk("R2", "blk_len low", blk_len, 16'h56BB);

    // R3 port config and discarded timing byte
    wr(8'h54);
    chk("R3", "cfg_a", cfg_a, 8'h54);
    chk("R3", "pend timing", pend_cnt, 1);
    wr(8'hFF);
    chk("R3", "pend after timing", pend_cnt, 0);
    chk("R3", "start_a kept", start_a, 16'h12AA);
    chk("R3", "blk_len kept", blk_len, 16'h56BB);
    chk("R3", "cfg_b kept", cfg_b, 8'h00);
    wr(8'h08);
    chk("R3", "cfg_b", cfg_b, 8'h08);
    chk("R3", "cfg_a kept", cfg_a, 8'h54);

    // R4 mask/match, interrupt and channel enable
    wr(8'hF8);
    chk("R4", "pend", pend_cnt, 2);
    chk("R4", "int_en", int_en, 1);
    chk("R4", "chan_en", chan_en, 1);
    wr(8'h0F); wr(8'hC5);
    chk("R4", "mask", mask, 8'h0F);
    chk("R4", "match", match_val, 8'hC5);

    // R5 / R6 mode byte with interrupt control appending two bytes
    wr(8'hBD);
    chk("R5", "op_mode", op_mode, 1);
    chk("R5", "pend", pend_cnt, 3);
    wr(8'hEF); wr(8'hBE);
    chk("R5", "start_b", start_b, 16'hBEEF);
    wr(8'h18);
    chk("R6", "pend after append", pend_cnt, 2);
    chk("R6", "int_ctl", int_ctl, 8'h18);
    wr(8'h33); wr(8'h44);
    chk("R6", "pulse", int_pulse, 8'h33);
    chk("R6", "vector", int_vec, 8'h44);
    chk("R6", "pend end", pend_cnt, 0);
    wr(8'h91); wr(8'h10);
    chk("R6", "vector only pend", pend_cnt, 1);
    wr(8'h99);
    chk("R6", "vector only", int_vec, 8'h99);
    chk("R6", "pulse untouched", int_pulse, 8'h33);
    wr(8'hC1);
    chk("R5", "op_mode 2", op_mode, 2);
    wr(8'hFD);
    chk("R5", "mode 11 ignored", op_mode, 2);
    chk("R5", "mode 11 no queue", pend_cnt, 0);

    // R7 ready control guard
    wr(8'h8A);
    chk("R7", "ready write", ready_ctl, 8'h8A);
    wr(8'hCA);
    chk("R7", "bit6 ignored", ready_ctl, 8'h8A);
    wr(8'h8E);
    chk("R7", "bit2 ignored", ready_ctl, 8'h8A);

    // R8 load
    rep(1'b0, 1'b1, 1'b1);
    chk("R13", "match flag set", match_flag, 1);
    chk("R13", "endb flag set", endb_flag, 1);
    wr(8'hCF);
    chk("R8", "cnt_a", cnt_a, 16'h12AA);
    chk("R8", "cnt_b", cnt_b, 16'hBEEF);
    chk("R8", "flags", {match_flag, endb_flag}, 0);

    // R13 step report, R9 continue
    rep(1'b1, 1'b0, 1'b0);
    chk("R13", "step pend", step_pend, 1);
    chk("R13", "byte_cnt", byte_cnt, 1);
    wr(8'hD3);
    chk("R9", "cnt_a up", cnt_a, 16'h12AB);
    chk("R9", "cnt_b down", cnt_b, 16'hBEEE);
    chk("R9", "byte_cnt clr", byte_cnt, 0);
    chk("R9", "step clr", step_pend, 0);
    chk("R9", "chan_en", chan_en, 1);
    wr(8'hD3);
    chk("R9", "no step cnt_a", cnt_a, 16'h12AB);
    wr(8'h28);
    rep(1'b1, 1'b0, 1'b0);
    wr(8'hD3);
    chk("R9", "cnt_a up again", cnt_a, 16'h12AC);
    chk("R9", "cnt_b fixed", cnt_b, 16'hBEEE);

    // R10 reset command
    rep(1'b1, 1'b0, 1'b0);
    wr(8'hC3);
    chk("R10", "xfer low bits", xfer_mode, 8'h28);
    chk("R10", "int_en", int_en, 0);
    chk("R10", "step", step_pend, 0);
    chk("R10", "chan_en kept", chan_en, 1);

    // R11 enable, interrupt on/off, clear flags
    rep(1'b1, 1'b0, 1'b0);
    wr(8'h87);
    chk("R11", "enable clears step", step_pend, 0);
    chk("R11", "enable chan", chan_en, 1);
    wr(8'hAB);
    chk("R11", "int on", int_en, 1);
    wr(8'hAF);
    chk("R11", "int off", int_en, 0);
    rep(1'b0, 1'b1, 1'b0);
    wr(8'h8B);
    chk("R11", "flags cleared", match_flag, 0);
    // R13 clear wins over a same-cycle report
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h8B; match = 1'b1; endb = 1'b1;
    @(negedge clk); wr_en = 1'b0; match = 1'b0; endb = 1'b0;
    chk("R13", "clear wins", {match_flag, endb_flag}, 0);

    // R12 read commands and pulses
    wr(8'hBB);
    chk("R12", "read mask queued", pend_cnt, 1);
    wr(8'h7E);
    chk("R12", "rd_mask", rd_mask, 8'h7E);
    chk("R12", "restart pulse", rd_restart, 1);
    @(negedge clk);
    chk("R12", "restart one cycle", rd_restart, 0);
    wr(8'hBF);
    chk("R12", "status mask", rd_mask, 8'h01);
    chk("R12", "status restart", rd_restart, 1);
    wr(8'hA7);
    chk("R12", "start restart", rd_restart, 1);
    wr(8'hB3);
    chk("R12", "force ready", force_ready, 1);
    @(negedge clk);
    chk("R12", "force ready one cycle", force_ready, 0);

    // random frames: R2, R5, R8, R9
    for (int it = 0; it < 30; it++) begin
      logic [15:0] a, b, l;
      logic [1:0]  dir;
      a = 16'($urandom); b = 16'($urandom); l = 16'($urandom);
      dir = 2'($urandom_range(0, 2));
      wr(8'h79); wr(a[7:0]); wr(a[15:8]); wr(l[7:0]); wr(l[15:8]);
      wr(8'h8D); wr(b[7:0]); wr(b[15:8]);
      wr({2'b00, dir, 4'b0100});
      wr(8'hCF);
      chk("R2", "rand start_a", start_a, a);
      chk("R2", "rand blk_len", blk_len, l);
      chk("R5", "rand start_b", start_b, b);
      chk("R8", "rand cnt_b", cnt_b, b);
      rep(1'b1, 1'b0, 1'b0);
      wr(8'hD3);
      chk("R9", "rand cnt_a step", cnt_a, exp_step(a, dir));
      chk("R14", "rand pend", pend_cnt, 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule